// File: doc/BRIEF.md
# Vector set-first mask unit

This block applies one of three prefix-scan operations to a vector mask register. It walks the elements from index 0 upward and finds the first active element whose source mask bit is set. Depending on the selected operation, it marks every active element before that point, every active element up to and including it, or only that element. It is used as the execution stage for the set-before-first, set-including-first and set-only-first mask instructions. The decoder hands it the operation field, the active length, the element stride and the operand registers.

The result is built on top of the prior destination contents. Elements that the governing mask disables keep their old bits, and so do bits that fall between element positions. Elements from the active length up to the last element the register holds are cleared. When the active length is zero, nothing is written. The result is registered: a `start` pulse is answered by a one-cycle `done` pulse on the next clock edge, and the result register then holds that value until the next `start`.

Top module: `vset_first_mask`

## Requirements
- R1: `op_sel` selects the operation: 5'b00001 is set-before-first, 5'b00011 is set-including-first and 5'b00010 is set-only-first. Any other value leaves the whole destination equal to `old_dst`.
- R2: `mlen_log2` gives the element stride MLEN = 2**mlen_log2. Element i sits at bit i*MLEN, and the register holds VLEN/MLEN elements. Bits that are not at an element position keep their `old_dst` value.
- R3: With `mask_en` = 0, an element whose `gov_mask` bit (at its element position) is 0 is inactive. It keeps its `old_dst` bit and takes no part in finding the first set element. With `mask_en` = 1, every element below `vl` is active.
- R4: Active elements before the first active set source bit are written 1 by set-before-first and set-including-first, and 0 by set-only-first.
- R5: At the first active element whose `src_mask` bit is 1, set-before-first writes 0 and the other two operations write 1.
- R6: Every active element after the first active set element is written 0.
- R7: If no active element has its source bit set, set-before-first and set-including-first write 1 to all active elements, and set-only-first writes 0 to all of them.
- R8: Element positions with index from `vl` up to VLEN/MLEN-1 are written 0.
- R9: When `vl` is 0, the destination equals `old_dst` in full.
- R10: After reset, `result` and `done` are 0. A `start` sampled at a clock edge produces `done` = 1 and the new `result` after that edge. Without `start`, `done` is 0 and `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compute request, sampled on the rising edge |
| op_sel | input | 5 | Operation selector field |
| mask_en | input | 1 | 1: all elements active; 0: the governing mask decides |
| vl | input | $clog2(VLEN)+1 | Active element count |
| mlen_log2 | input | $clog2($clog2(VLEN)+1) | log2 of the element stride |
| src_mask | input | VLEN | Source mask register |
| gov_mask | input | VLEN | Governing mask register |
| old_dst | input | VLEN | Prior destination contents |
| result | output | VLEN | Registered destination mask |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench builds the block with VLEN = 16. With that width, every legal stride from 1 to 16 can be selected, including the stride of 16 where the register holds a single element. A small register also lets hand-worked expected values be written out in full for each operation. Directed cases cover the first set bit before, at and beyond `vl`, as well as inactive elements that hide a set source bit. A pseudo-random sweep over all three operations, strides, lengths and masks is compared against an element-indexed model.

// File: rtl/vset_first_mask.sv
module vset_first_mask #(
  parameter int VLEN = 128,
  localparam int LOGV = $clog2(VLEN),
  localparam int VLW  = LOGV + 1,
  localparam int MLW  = (LOGV > 0) ? $clog2(LOGV + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      op_sel,
  input  logic            mask_en,
  input  logic [VLW-1:0]  vl,
  input  logic [MLW-1:0]  mlen_log2,
  input  logic [VLEN-1:0] src_mask,
  input  logic [VLEN-1:0] gov_mask,
  input  logic [VLEN-1:0] old_dst,
  output logic [VLEN-1:0] result,
  output logic            done
);

  localparam logic [4:0] OP_BEFORE = 5'b00001;
  localparam logic [4:0] OP_INCL   = 5'b00011;
  localparam logic [4:0] OP_ONLY   = 5'b00010;

  logic            op_ok;
  logic [VLEN-1:0] nxt;

  assign op_ok = (op_sel == OP_BEFORE) || (op_sel == OP_INCL) || (op_sel == OP_ONLY);

  always_comb begin
    logic seen;
    seen = 1'b0;
    nxt  = old_dst;
    for (int b = 0; b < VLEN; b++) begin
      int  idx;
      int  low;
      idx = b >> mlen_log2;
      low = b & ((1 << mlen_log2) - 1);
      if (op_ok && (vl != '0) && (low == 0)) begin
        if (idx >= int'(vl)) begin
          nxt[b] = 1'b0;
        end else if (mask_en || gov_mask[b]) begin
          if (seen) begin
            nxt[b] = 1'b0;
          end else if (src_mask[b]) begin
            seen   = 1'b1;
            nxt[b] = (op_sel != OP_BEFORE);
          end else begin
            nxt[b] = (op_sel != OP_ONLY);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) result <= nxt;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(result)));
  assert_vl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl == '0) |=> (result == $past(old_dst)));
  assert_bad_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op_ok) |=> (result == $past(old_dst)));
  assert_only_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == OP_ONLY && mask_en && mlen_log2 == '0 && vl != '0) |=> $onehot0(result));
  assert_before_elem0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == OP_BEFORE && mask_en && vl != '0) |=> (result[0] == !$past(src_mask[0])));

endmodule

// File: tb/vset_first_mask_bench.sv
module vset_first_mask_bench;
  localparam int W   = 16;
  localparam int VLW = $clog2(W) + 1;
  localparam int MLW = $clog2($clog2(W) + 1);
  localparam logic [4:0] BEF = 5'b00001, INC = 5'b00011, ONL = 5'b00010;

  logic clk = 0, rst_n = 0, start = 0, mask_en = 1, done;
  logic [4:0] op_sel = BEF;
  logic [VLW-1:0] vl = '0;
  logic [MLW-1:0] mlen_log2 = '0;
  logic [W-1:0] src_mask = '0, gov_mask = '0, old_dst = '0, result;
  int checks = 0, failures = 0, cycles = 0;
  logic [31:0] lfsr = 32'h1234_abcd;

  vset_first_mask #(.VLEN(W)) u_vset_first_mask (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .mask_en(mask_en),
    .vl(vl), .mlen_log2(mlen_log2), .src_mask(src_mask), .gov_mask(gov_mask),
    .old_dst(old_dst), .result(result), .done(done));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(logic [4:0] op, logic en, int n, int mlog,
                                         logic [W-1:0] s, logic [W-1:0] g, logic [W-1:0] o);
    logic [W-1:0] r = o;
    bit found = 0;
    int nel = W >> mlog;
    if (n == 0 || !(op == BEF || op == INC || op == ONL)) return o;
    for (int e = 0; e < nel; e++) begin
      int p = e << mlog;
      if (e >= n) r[p] = 0;
      else if (en || g[p]) begin
        if (found) r[p] = 0;
        else if (s[p]) begin found = 1; r[p] = (op == BEF) ? 1'b0 : 1'b1; end
        else r[p] = (op == ONL) ? 1'b0 : 1'b1;
      end
    end
    return r;
  endfunction

  task automatic run(logic [4:0] op, logic en, int n, int mlog,
                     logic [W-1:0] s, logic [W-1:0] g, logic [W-1:0] o);
    @(negedge clk);
    op_sel = op; mask_en = en; vl = VLW'(n); mlen_log2 = MLW'(mlog);
    src_mask = s; gov_mask = g; old_dst = o; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset();
    check("R10 reset result", result, '0);
    check("R10 reset done", {15'b0, done}, '0);
  endtask

  task automatic t_basic();
    run(BEF, 1, 16, 0, 16'h0028, 16'h0000, 16'hF0F0);
    check("R4 R5 before-first", result, 16'h0007);
    check("R10 done pulse", {15'b0, done}, 16'h1);
    run(INC, 1, 16, 0, 16'h0028, 16'h0000, 16'hF0F0);
    check("R5 R6 including-first", result, 16'h000F);
    run(ONL, 1, 16, 0, 16'h0028, 16'h0000, 16'hF0F0);
    check("R4 R5 R6 only-first", result, 16'h0008);
  endtask

  task automatic t_masked();
    run(INC, 0, 16, 0, 16'h0028, 16'hFFF7, 16'h0008);
    check("R3 inactive bit kept, scan skips it", result, 16'h003F);
    run(ONL, 0, 16, 0, 16'h0028, 16'h00F7, 16'hAB08);
    check("R3 only-first with governing mask", result, 16'hAB28);
  endtask

  task automatic t_noset();
    run(BEF, 1, 16, 0, 16'h0000, 16'h0000, 16'h1234);
    check("R7 before-first no set bit", result, 16'hFFFF);
    run(INC, 1, 16, 0, 16'h0000, 16'h0000, 16'h1234);
    check("R7 including-first no set bit", result, 16'hFFFF);
    run(ONL, 1, 16, 0, 16'h0000, 16'h0000, 16'h1234);
    check("R7 only-first no set bit", result, 16'h0000);
  endtask

  task automatic t_tail();
    run(BEF, 1, 5, 0, 16'h0100, 16'h0000, 16'hFFFF);
    check("R8 tail cleared, set bit beyond vl ignored", result, 16'h001F);
  endtask

  task automatic t_vl0();
    run(INC, 1, 0, 0, 16'h00FF, 16'h0000, 16'h5A5A);
    check("R9 vl zero leaves destination", result, 16'h5A5A);
  endtask

  task automatic t_stride();
    run(INC, 1, 3, 2, 16'h0010, 16'h0000, 16'hAAAA);
    check("R2 stride 4 element positions", result, 16'hAABB);
    run(BEF, 1, 1, 4, 16'h0000, 16'h0000, 16'hFFFE);
    check("R2 stride 16 single element", result, 16'hFFFF);
  endtask

  task automatic t_badop();
    run(5'b00111, 1, 16, 0, 16'h0001, 16'h0000, 16'h3C3C);
    check("R1 unknown selector leaves destination", result, 16'h3C3C);
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    run(ONL, 1, 16, 0, 16'h0400, 16'h0000, 16'h0000);
    held = result;
    src_mask = 16'hFFFF; old_dst = 16'hFFFF;
    @(negedge clk);
    check("R10 done drops", {15'b0, done}, '0);
    check("R10 result held without start", result, held);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 60; k++) begin
      logic [4:0] op;
      int mlog, n;
      logic [W-1:0] s, g, o;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op   = (k % 3 == 0) ? BEF : (k % 3 == 1) ? INC : ONL;
      mlog = (k / 3) % 5;
      n    = int'(lfsr[4:0]) % 17;
      s    = lfsr[20:5] & lfsr[31:16];
      g    = lfsr[15:0] ^ lfsr[31:16];
      o    = ~lfsr[23:8];
      run(op, lfsr[7], n, mlog, s, g, o);
      check("R2 R3 R4 R5 R6 R7 R8 sweep", result, model(op, lfsr[7], n, mlog, s, g, o));
    end
  endtask

  initial begin
    #1;
    t_reset();
    #5 rst_n = 1;
    t_basic();
    t_masked();
    t_noset();
    t_tail();
    t_vl0();
    t_stride();
    t_badop();
    t_hold();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule